// File: doc/BRIEF.md
# Rotating Reprogrammable Twiddle Bank Set

This block stores the twiddle factors for a fully streaming radix-2 number theoretic transform datapath whose prime field can change from one transform to the next. It does not keep a table for every field. Instead it holds a small ring of G banks, and each bank holds the complete twiddle set of one field. The set is arranged by stage and by way. A transform entering the datapath is bound to the bank that the ring points at. Each stage then reads that bank for as long as the transform occupies the stage.

Once the last stage has finished with a bank, the bank is free to be rewritten with the twiddles of a field that has not been started yet. Transforms can therefore start every T = N/W cycles without bubbles. Each bank has its own programming port: one write enable and one write address per (stage, way) slot, and W/2 twiddle words.

Within a stage, a slot that holds a single twiddle is a plain register. A slot that holds several twiddles is a small memory, indexed by that stage's read address.

Top module: `twiddle_bank_set`

## Requirements
- R1: After reset, prgBank is 0, prgErr is 0 and every twiddle output is 0.
- R2: prgBank names the bank that the next start pulse will bind. It advances by one, modulo G, in the cycle after each startIn pulse, and it holds its value otherwise.
- R3: A startIn pulse binds the bank named by prgBank. Stage l switches to that bank l·STAGE_GAP clock edges after the start edge (STAGE_GAP is 1 by default). The stage keeps reading that bank until the next transform reaches it. Before any start, every stage reads bank 0.
- R4: Stage l, way t holds max(1, 2^l/(W/2)) entries. With the defaults these are 1, 1, 2 and 4 entries for stages 0 to 3. The entry presented on a read is selected by the low bits of that stage's read address, and a write goes to the entry selected by the low bits of the write address. One-entry slots ignore both addresses.
- R5: The bit prgWe[(g·S+l)·(W/2)+t] writes twiddle word t of bank g into slot (l,t) of bank g. That word is prgData[(g·(W/2)+t)·DW +: DW], and the write address is prgAddr[((g·S+l)·(W/2)+t)·AW +: AW]. If stage l currently reads bank g, the new value appears on its output in the next cycle.
- R6: A bank is busy from the edge on which it is bound until (S−1)·STAGE_GAP + T − 1 further edges have passed. With the defaults, writes on the 6 edges after the start edge are refused, and writes from the 7th edge on are accepted.
- R7: A write enable aimed at a busy bank leaves that bank unchanged, and prgErr is 1 in the following cycle.
- R8: prgErr is 0 in every cycle that does not follow a write to a busy bank.
- R9: When transforms start back to back every T cycles and the freed banks are reprogrammed in flight, every stage presents the twiddles of its own transform's field in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Pulse marking a transform entering the datapath |
| rdAddr | input | S·AW | Read address per stage |
| twOut | output | S·(W/2)·DW | Twiddle per (stage, way) |
| prgWe | input | G·S·(W/2) | Write enable per bank, stage and way |
| prgAddr | input | G·S·(W/2)·AW | Write address per bank, stage and way |
| prgData | input | G·(W/2)·DW | W/2 twiddle words per bank |
| prgBank | output | BW | Bank that the next start binds |
| prgErr | output | 1 | Write to a busy bank happened on the previous edge |

## Verification
The first pattern programs a bank with no transform running and sweeps the read addresses. This separates the slot depths from one another and shows that one-entry slots ignore both addresses. The second pattern starts two transforms on two different fields. The staggered switch from one field's values to the other's shows whether each stage moves to the new bank on exactly its own edge. The third pattern streams twelve transforms back to back while the freed banks are rewritten. This catches wrong ring order, early reuse of a bank, and writes that land in the wrong bank. The last pattern writes to a bank one edge before its release and again on the release edge, which pins the busy window to an exact edge.

// File: rtl/twb_pkg.sv
package twb_pkg;
  parameter int N_PTS     = 16;  // transform size
  parameter int STREAM_W  = 4;   // samples per cycle
  parameter int N_BANKS   = 4;   // ring size G
  parameter int TW_W      = 16;  // twiddle word width
  parameter int STAGE_GAP = 1;   // edges between consecutive stages taking a transform

  localparam int STAGES    = $clog2(N_PTS);
  localparam int WAYS      = STREAM_W / 2;
  localparam int PERIOD    = N_PTS / STREAM_W;
  localparam int MAX_DEPTH = N_PTS / STREAM_W;
  localparam int AW        = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
  localparam int BW        = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
  localparam int PIPE      = (STAGES - 1) * STAGE_GAP;
  localparam int HOLD      = PIPE + PERIOD - 1;
  localparam int CW        = $clog2(HOLD + 1);

  function automatic int slotDepth(int l);
    int d;
    d = (1 << l) / WAYS;
    return (d < 1) ? 1 : d;
  endfunction

  // strobes from control to storage
  typedef struct packed {
    logic [N_BANKS-1:0]            wrOk;
    logic [STAGES-1:0][BW-1:0]     stageSel;
  } twb_ctl_t;
endpackage

// File: rtl/twb_ctrl.sv
module twb_ctrl
  import twb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [N_BANKS-1:0] bankWr,
  output twb_ctl_t           ctl,
  output logic [BW-1:0]      nextBank,
  output logic               wrErr
);
  logic [BW-1:0]                 curBank;
  logic [PIPE-1:0]               pipeV;
  logic [PIPE-1:0][BW-1:0]       pipeB;
  logic [STAGES-1:0][BW-1:0]     sel;
  logic [N_BANKS-1:0][CW-1:0]    busyCnt;
  logic [N_BANKS-1:0]            freeMask;

  always_comb begin
    for (int g = 0; g < N_BANKS; g++) freeMask[g] = (busyCnt[g] == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBank <= '0;
      pipeV   <= '0;
      pipeB   <= '0;
      sel     <= '0;
      busyCnt <= '0;
      wrErr   <= 1'b0;
    end else begin
      if (startIn) begin
        curBank <= (curBank == BW'(N_BANKS - 1)) ? '0 : curBank + 1'b1;
        sel[0]  <= curBank;
      end
      // start tokens travel down the stages
      pipeV[0] <= startIn;
      pipeB[0] <= curBank;
      for (int k = 1; k < PIPE; k++) begin
        pipeV[k] <= pipeV[k-1];
        pipeB[k] <= pipeB[k-1];
      end
      for (int l = 1; l < STAGES; l++) begin
        if (pipeV[l*STAGE_GAP-1]) sel[l] <= pipeB[l*STAGE_GAP-1];
      end
      // busy window per bank
      for (int g = 0; g < N_BANKS; g++) begin
        if (startIn && curBank == BW'(g)) busyCnt[g] <= CW'(HOLD);
        else if (busyCnt[g] != '0)        busyCnt[g] <= busyCnt[g] - 1'b1;
      end
      wrErr <= |(bankWr & ~freeMask);
    end
  end

  always_comb begin
    ctl.wrOk     = freeMask;
    ctl.stageSel = sel;
  end

  assign nextBank = curBank;
endmodule

// File: rtl/twb_store.sv
module twb_store
  import twb_pkg::*;
(
  input  logic                                         clk,
  input  logic                                         rstN,
  input  twb_ctl_t                                     ctl,
  input  logic [STAGES-1:0][AW-1:0]                    rdAddr,
  input  logic [N_BANKS-1:0][STAGES-1:0][WAYS-1:0]     we,
  input  logic [N_BANKS-1:0][STAGES-1:0][WAYS-1:0][AW-1:0] wAddr,
  input  logic [N_BANKS-1:0][WAYS-1:0][TW_W-1:0]       wData,
  output logic [STAGES-1:0][WAYS-1:0][TW_W-1:0]        twOut
);
  logic [STAGES-1:0][WAYS-1:0][N_BANKS-1:0][TW_W-1:0] rdVal;

  for (genvar g = 0; g < N_BANKS; g++) begin : gBank
    for (genvar l = 0; l < STAGES; l++) begin : gStage
      for (genvar t = 0; t < WAYS; t++) begin : gWay
        localparam int D = slotDepth(l);
        logic wrEn;
        assign wrEn = we[g][l][t] & ctl.wrOk[g];
        if (D == 1) begin : gReg
          logic [TW_W-1:0] val;
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN)     val <= '0;
            else if (wrEn) val <= wData[g][t];
          end
          assign rdVal[l][t][g] = val;
        end else begin : gMem
          localparam int IW = $clog2(D);
          logic [D-1:0][TW_W-1:0] mem;
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN)     mem <= '0;
            else if (wrEn) mem[wAddr[g][l][t][IW-1:0]] <= wData[g][t];
          end
          assign rdVal[l][t][g] = mem[rdAddr[l][IW-1:0]];
        end
      end
    end
  end

  for (genvar l = 0; l < STAGES; l++) begin : gMuxStage
    for (genvar t = 0; t < WAYS; t++) begin : gMuxWay
      assign twOut[l][t] = rdVal[l][t][ctl.stageSel[l]];
    end
  end
endmodule

// File: rtl/twiddle_bank_set.sv
module twiddle_bank_set
  import twb_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 startIn,
  input  logic [STAGES*AW-1:0]                 rdAddr,
  output logic [STAGES*WAYS*TW_W-1:0]          twOut,
  input  logic [N_BANKS*STAGES*WAYS-1:0]       prgWe,
  input  logic [N_BANKS*STAGES*WAYS*AW-1:0]    prgAddr,
  input  logic [N_BANKS*WAYS*TW_W-1:0]         prgData,
  output logic [BW-1:0]                        prgBank,
  output logic                                 prgErr
);
  twb_ctl_t ctl;
  logic [N_BANKS-1:0][STAGES*WAYS-1:0] weGrp;
  logic [N_BANKS-1:0]                  bankWr;

  assign weGrp = prgWe;
  always_comb begin
    for (int g = 0; g < N_BANKS; g++) bankWr[g] = |weGrp[g];
  end

  twb_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .bankWr   (bankWr),
    .ctl      (ctl),
    .nextBank (prgBank),
    .wrErr    (prgErr)
  );

  twb_store uStore (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .rdAddr (rdAddr),
    .we     (prgWe),
    .wAddr  (prgAddr),
    .wData  (prgData),
    .twOut  (twOut)
  );
endmodule

// File: rtl/twb_checks.sv
module twb_checks
  import twb_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           startIn,
  input logic [N_BANKS*STAGES*WAYS-1:0] prgWe,
  input logic [BW-1:0]                  prgBank,
  input logic                           prgErr,
  input logic [BW-1:0]                  firstSel,
  input logic [N_BANKS-1:0]             wrOk
);
  logic [N_BANKS-1:0][STAGES*WAYS-1:0] weGrp;
  logic busyHit;

  assign weGrp = prgWe;
  always_comb begin
    busyHit = 1'b0;
    for (int g = 0; g < N_BANKS; g++) busyHit = busyHit | ((|weGrp[g]) & ~wrOk[g]);
  end

  a_r2_ring_advance: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> prgBank == (($past(prgBank) == BW'(N_BANKS - 1)) ? '0 : BW'($past(prgBank) + 1'b1)));

  a_r2_ring_hold: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> $stable(prgBank));

  a_r3_first_stage_bind: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> firstSel == $past(prgBank));

  a_r7_busy_flag: assert property (@(posedge clk) disable iff (!rstN)
    busyHit |=> prgErr);

  a_r8_quiet_flag: assert property (@(posedge clk) disable iff (!rstN)
    !busyHit |=> !prgErr);
endmodule

bind twiddle_bank_set twb_checks uChecks (
  .clk      (clk),
  .rstN     (rstN),
  .startIn  (startIn),
  .prgWe    (prgWe),
  .prgBank  (prgBank),
  .prgErr   (prgErr),
  .firstSel (ctl.stageSel[0]),
  .wrOk     (ctl.wrOk)
);

// File: tb/tb_twiddle_bank_set.sv
module tb_twiddle_bank_set;
  import twb_pkg::*;
  localparam int SLOTS = STAGES * WAYS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                          rstN;
  logic                          startIn;
  logic [STAGES*AW-1:0]          rdAddr;
  logic [SLOTS*TW_W-1:0]         twOut;
  logic [N_BANKS*SLOTS-1:0]      prgWe;
  logic [N_BANKS*SLOTS*AW-1:0]   prgAddr;
  logic [N_BANKS*WAYS*TW_W-1:0]  prgData;
  logic [BW-1:0]                 prgBank;
  logic                          prgErr;

  twiddle_bank_set dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .rdAddr(rdAddr), .twOut(twOut),
    .prgWe(prgWe), .prgAddr(prgAddr), .prgData(prgData),
    .prgBank(prgBank), .prgErr(prgErr)
  );

  int checks = 0;
  int fails = 0;
  int edgeNo = 0;
  int nStarts = 0;
  bit finished = 0;
  bit expErr = 0;
  int model [N_BANKS][STAGES][WAYS][MAX_DEPTH];
  int lastStart [N_BANKS];
  bit used [N_BANKS];
  int startE [512];
  int startB [512];

  function automatic int twVal(int f, int l, int t, int a);
    return f * 256 + l * 32 + t * 8 + a + 1;
  endfunction

  // programming row r of a bank: stage 0, stage 1, stage 2 x2, stage 3 x4
  function automatic int rowStage(int r);
    return (r == 0) ? 0 : (r == 1) ? 1 : (r < 4) ? 2 : 3;
  endfunction
  function automatic int rowAddr(int r);
    return (r < 2) ? 0 : (r < 4) ? r - 2 : r - 4;
  endfunction

  // bank read by stage l now (R3): latest start at least l*STAGE_GAP edges back
  function automatic int stageBank(int l);
    int b = 0;
    for (int j = 0; j < nStarts; j++)
      if (startE[j] <= edgeNo - l * STAGE_GAP) b = startB[j];
    return b;
  endfunction

  task automatic chk(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic clearDrive();
    startIn = 1'b0;
    prgWe   = '0;
    prgAddr = '0;
    prgData = '0;
  endtask

  task automatic driveRow(int g, int r, int field);
    int l, a, d, wa, idx;
    l = rowStage(r);
    a = rowAddr(r);
    d = slotDepth(l);
    wa = (d < MAX_DEPTH) ? a + d : a;  // upper bits must be ignored (R4)
    for (int t = 0; t < WAYS; t++) begin
      idx = (g * STAGES + l) * WAYS + t;
      prgWe[idx] = 1'b1;
      prgAddr[idx*AW +: AW] = AW'(wa);
      prgData[(g*WAYS+t)*TW_W +: TW_W] = TW_W'(twVal(field, l, t, a));
    end
  endtask

  task automatic checkAll(string tag);
    int b, a;
    chk("R2", int'(prgBank), nStarts % N_BANKS, "prgBank");
    chk(expErr ? "R7" : "R8", int'(prgErr), int'(expErr), "prgErr");
    for (int l = 0; l < STAGES; l++) begin
      b = stageBank(l);
      a = int'(rdAddr[l*AW +: AW]) % slotDepth(l);
      for (int t = 0; t < WAYS; t++)
        chk(tag, int'(twOut[(l*WAYS+t)*TW_W +: TW_W]), model[b][l][t][a],
            $sformatf("stage %0d way %0d bank %0d", l, t, b));
    end
  endtask

  task automatic step(string tag);
    int idx, b;
    for (int l = 0; l < STAGES; l++) rdAddr[l*AW +: AW] = AW'(edgeNo * 3 + l);
    @(posedge clk);
    edgeNo++;
    expErr = 0;
    for (int g = 0; g < N_BANKS; g++)
      for (int l = 0; l < STAGES; l++)
        for (int t = 0; t < WAYS; t++) begin
          idx = (g * STAGES + l) * WAYS + t;
          if (prgWe[idx]) begin
            if (!used[g] || edgeNo >= lastStart[g] + HOLD + 1)
              model[g][l][t][int'(prgAddr[idx*AW +: AW]) % slotDepth(l)] =
                int'(prgData[(g*WAYS+t)*TW_W +: TW_W]);
            else
              expErr = 1;
          end
        end
    if (startIn) begin
      b = nStarts % N_BANKS;
      startE[nStarts] = edgeNo;
      startB[nStarts] = b;
      nStarts++;
      lastStart[b] = edgeNo;
      used[b] = 1;
    end
    @(negedge clk);
    checkAll(tag);
    clearDrive();
  endtask

  task automatic programBank(int g, int field, string tag);
    for (int r = 0; r < 8; r++) begin
      driveRow(g, r, field);
      step(tag);
    end
  endtask

  // R1: reset state
  task automatic testReset();
    rstN = 1'b0;
    clearDrive();
    rdAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkAll("R1");
  endtask

  // R5 and R4: program idle bank 0, then sweep read addresses
  task automatic testProgram();
    programBank(0, 1, "R5");
    repeat (8) step("R4");
  endtask

  // R3: two transforms on two fields, staggered stage switch
  task automatic testBinding();
    programBank(1, 2, "R5");
    startIn = 1'b1;
    step("R3");
    repeat (6) step("R3");
    startIn = 1'b1;
    step("R3");
    repeat (8) step("R3");
  endtask

  // R9: back-to-back stream with in-flight reprogramming
  task automatic testStream();
    int ns0, r;
    int nt = 12;
    repeat (8) step("R9");
    ns0 = nStarts;
    for (int j = 0; j < N_BANKS; j++) programBank((ns0 + j) % N_BANKS, 10 + j, "R9");
    for (int c = 0; c < 4 * nt + 8; c++) begin
      if (c % PERIOD == 0 && c / PERIOD < nt) startIn = 1'b1;
      for (int j = N_BANKS; j < nt; j++) begin
        r = c - (PERIOD * (j - N_BANKS) + HOLD + 1);
        if (r >= 0 && r < 8) driveRow((ns0 + j) % N_BANKS, r, 10 + j);
      end
      step("R9");
    end
  endtask

  // R6 and R7: write one edge early (refused), then on the release edge (accepted)
  task automatic testBusy();
    int g;
    repeat (8) step("R8");
    g = nStarts % N_BANKS;
    startIn = 1'b1;
    step("R6");
    repeat (5) step("R6");
    driveRow(g, 0, 99);
    step("R7");
    driveRow(g, 0, 99);
    step("R6");
    repeat (3) step("R6");
  endtask

  initial begin
    for (int g = 0; g < N_BANKS; g++) begin
      used[g] = 0;
      lastStart[g] = 0;
      for (int l = 0; l < STAGES; l++)
        for (int t = 0; t < WAYS; t++)
          for (int a = 0; a < MAX_DEPTH; a++) model[g][l][t][a] = 0;
    end
    testReset();
    testProgram();
    testBinding();
    testStream();
    testBusy();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule